// File: doc/BRIEF.md
# Instruction Cache Invalidation Walker

This block empties a read-only first-level instruction cache on demand. A single sync request starts a sweep across the tag array. The sweep starts at line index zero and ends at the highest index. For every index it hands the cache controller one eviction request over a valid/ready port. Each eviction that the port accepts drops that line's valid bit, whatever the line held before. The controller reports each finished eviction on a one-cycle callback input. A counter tracks how many evictions are still in flight. The block raises a one-cycle completion pulse only after two things are true: the sweep has issued its last index, and the counter has returned to zero.

The sync request is never forwarded as an ordinary memory access, and it holds no address of its own. While a sweep is running, line fills and instruction fetches are stalled. A second sync request during a sweep is ignored. A callback that arrives when nothing is owed is also ignored. Both of these cases raise a sticky protocol-error flag, which only reset clears. The tag array is modelled here as a vector of valid bits. It has a fill port and a probe port so that its contents can be seen from outside.

Top module: `icache_inval_walker`

## Requirements
- R1: After reset, no eviction is offered, the stall and error outputs are low, no completion is signalled, and every line probes invalid.
- R2: A sync request accepted while idle produces exactly one accepted eviction per line, with indices 0, 1, ..., NUM_LINES-1 in that order.
- R3: While `evict_ready` is low, `evict_valid` stays high and `evict_idx` keeps its value.
- R4: An accepted eviction leaves that line invalid (`probe_hit` = 0), whether the line was valid or invalid before.
- R5: `sync_done` is high for exactly one cycle per sync. It rises only when all NUM_LINES evictions have been accepted and every one of them has been answered on `evict_done`.
- R6: Each `evict_done` pulse retires one outstanding eviction. While any eviction is unanswered, no completion is signalled, however many lines have been issued.
- R7: An `evict_done` pulse while idle, or while nothing is outstanding, sets `proto_err` from the next cycle on. `proto_err` stays high until reset.
- R8: A `sync_req` while a sweep is active sets `proto_err` and does not restart or disturb the sweep in progress.
- R9: `fetch_stall` is high from the cycle after a sync is accepted until the cycle after `sync_done`. A fill presented during that time is dropped.
- R10: While idle, a `fill_valid` pulse on index i makes line i probe valid from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_req | input | 1 | Whole-cache invalidate request (one-cycle pulse) |
| sync_done | output | 1 | One-cycle completion of the held sync |
| evict_valid | output | 1 | Eviction request offered to the cache controller |
| evict_ready | input | 1 | Controller accepts the offered eviction |
| evict_idx | output | IDX_W | Line index of the offered eviction |
| evict_done | input | 1 | One eviction has finished (one-cycle pulse) |
| fill_valid | input | 1 | Mark a line valid (dropped during a sweep) |
| fill_idx | input | IDX_W | Line index for the fill |
| fetch_stall | output | 1 | Fetches must wait; a sweep is active |
| probe_idx | input | IDX_W | Line index to inspect |
| probe_hit | output | 1 | Valid bit of the probed line |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The bench sweeps the cache under several mixes of back-pressure and callback latency. In each mix it checks the issued index order and looks for exactly one completion pulse. Two faults are aimed at directly. A design that counts completion from issued lines rather than answered ones would signal done early in the slow-callback cases. A design that releases the eviction port under back-pressure would skip or repeat indices. The bench also injects an overlapping sync in the middle of a sweep; a design that restarts on it would re-issue index 0. It presents a fill during a sweep, which a leaky stall would let through. It sends a callback while nothing is owed; a design that underflows its counter would hang or complete falsely, and neither case should leave the error flag clear.

// File: rtl/inval_walk_pkg.sv
// Shared types for the invalidation walker.
package inval_walk_pkg;
    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_SWEEP = 2'd1,
        WS_DRAIN = 2'd2
    } walk_state_t;
endpackage

// File: rtl/line_valid_array.sv
// Valid-bit model of the tag array.
// Assumes set and clear never target the same line in one cycle
// (fills are blocked by the caller during a sweep).
module line_valid_array #(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);
    logic [NUM_LINES-1:0] vbits;

    // Update valid bits on fill (set) and eviction (tag read + write -> clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbits <= '0;
        end else begin
            if (set_en) vbits[set_idx] <= 1'b1;
            if (clr_en) vbits[clr_idx] <= 1'b0;
        end
    end

    // Probe read.
    assign rd_bit = vbits[rd_idx];

    // R4
    line_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !vbits[$past(clr_idx)]);
endmodule

// File: rtl/evict_pend_ctr.sv
// Counts evictions issued but not yet answered.
// Flags callbacks that arrive with nothing owed, and does not apply them.
module evict_pend_ctr #(
    parameter int NUM_LINES = 8,
    localparam int CNT_W = $clog2(NUM_LINES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             issue,
    input  logic             done_in,
    output logic             zero,
    output logic             spurious
);
    logic [CNT_W-1:0] cnt;
    logic             dec;

    // Qualify the callback against the owed count.
    always_comb begin
        spurious = done_in && (!active || cnt == '0);
        dec      = done_in && !spurious;
    end

    // Net increment/decrement of the outstanding count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (issue && !dec) begin
            cnt <= cnt + 1'b1;
        end else if (dec && !issue) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(NUM_LINES));
endmodule

// File: rtl/walk_seq.sv
// Sweep sequencer: steps through line indices 0..NUM_LINES-1, one per accepted
// eviction, then waits for the outstanding count to drain before completing.
// Assumes NUM_LINES >= 2.
module walk_seq
    import inval_walk_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             out_ready,
    input  logic             pend_zero,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_idx,
    output logic             busy,
    output logic             finish,
    output logic             overlap
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LINES - 1);

    walk_state_t state;
    logic [IDX_W-1:0] idx;

    // State and index register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WS_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                WS_IDLE: if (start) begin
                    state <= WS_SWEEP;
                    idx   <= '0;
                end
                WS_SWEEP: if (out_ready) begin
                    if (idx == LAST) state <= WS_DRAIN;
                    else             idx   <= idx + 1'b1;
                end
                WS_DRAIN: if (pend_zero) state <= WS_IDLE;
                default: state <= WS_IDLE;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        out_valid = (state == WS_SWEEP);
        out_idx   = idx;
        busy      = (state != WS_IDLE);
        finish    = (state == WS_DRAIN) && pend_zero;
        overlap   = start && (state != WS_IDLE);
    end

    // R3
    evict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_idx)));
    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_idx != LAST) |=>
            (out_valid && out_idx == $past(out_idx) + 1'b1));
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (!finish && !busy));
endmodule

// File: rtl/icache_inval_walker.sv
// Whole-cache invalidation walker for a read-only instruction cache.
// Holds one sync at a time, sweeps evictions, counts callbacks, and completes
// once. Protocol violations set a sticky error and are otherwise ignored.
module icache_inval_walker #(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_req,
    output logic             sync_done,
    output logic             evict_valid,
    input  logic             evict_ready,
    output logic [IDX_W-1:0] evict_idx,
    input  logic             evict_done,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_idx,
    output logic             fetch_stall,
    input  logic [IDX_W-1:0] probe_idx,
    output logic             probe_hit,
    output logic             proto_err
);
    logic busy, pend_zero, spurious, overlap, accept;

    walk_seq #(.NUM_LINES(NUM_LINES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(sync_req), .out_ready(evict_ready),
        .pend_zero(pend_zero), .out_valid(evict_valid), .out_idx(evict_idx),
        .busy(busy), .finish(sync_done), .overlap(overlap)
    );

    assign accept = evict_valid && evict_ready;

    evict_pend_ctr #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk(clk), .rst_n(rst_n), .active(busy), .issue(accept),
        .done_in(evict_done), .zero(pend_zero), .spurious(spurious)
    );

    line_valid_array #(.NUM_LINES(NUM_LINES)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .set_en(fill_valid && !busy), .set_idx(fill_idx),
        .clr_en(accept), .clr_idx(evict_idx),
        .rd_idx(probe_idx), .rd_bit(probe_hit)
    );

    assign fetch_stall = busy;

    // Sticky protocol-error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                   proto_err <= 1'b0;
        else if (spurious || overlap) proto_err <= 1'b1;
    end

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
    // R9
    stall_during_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> fetch_stall);
endmodule

// File: tb/icache_inval_walker_bench.sv
module icache_inval_walker_bench;
    localparam int N     = 8;
    localparam int IDX_W = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_req = 0, evict_ready = 0, evict_done = 0, fill_valid = 0;
    logic [IDX_W-1:0] fill_idx = '0, probe_idx = '0;
    logic sync_done, evict_valid, fetch_stall, probe_hit, proto_err;
    logic [IDX_W-1:0] evict_idx;

    always #4 clk = ~clk;

    icache_inval_walker #(.NUM_LINES(N)) u_icache_inval_walker (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .sync_done(sync_done),
        .evict_valid(evict_valid), .evict_ready(evict_ready), .evict_idx(evict_idx),
        .evict_done(evict_done), .fill_valid(fill_valid), .fill_idx(fill_idx),
        .fetch_stall(fetch_stall), .probe_idx(probe_idx), .probe_hit(probe_hit),
        .proto_err(proto_err)
    );

    int n_chk = 0, n_fail = 0;
    int issued = 0, owed = 0, dones = 0;

    // {fill mask, ready pattern, callback pattern}
    localparam logic [23:0] VEC [6] = '{
        24'hFF_FF_FF, 24'h00_FF_01, 24'hA5_AA_FF,
        24'h3C_81_55, 24'h0F_FF_80, 24'hFF_33_0F
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle (caller is at a negedge), then observe.
    task automatic step(input bit rdy, input bit cb_ok);
        evict_ready = rdy;
        evict_done  = cb_ok && (owed > 0);
        if (evict_done) owed--;
        #1;
        chk(fetch_stall, "R9 stall while active", fetch_stall, 1);
        if (evict_valid && evict_ready) begin
            chk(int'(evict_idx) == issued, "R2 index order", evict_idx, issued);
            issued++;
            owed++;
        end
        if (sync_done) begin
            dones++;
            chk(issued == N && owed == 0, "R5/R6 done only when all answered", issued, N);
        end
    endtask

    task automatic finish_sweep();
        int guard = 0;
        while (dones == 0 && guard < 100) begin
            @(negedge clk);
            step(1'b1, 1'b1);
            guard++;
        end
        @(negedge clk);
        evict_ready = 0; evict_done = 0;
        #1;
        chk(!sync_done, "R5 single-cycle done", sync_done, 0);
        chk(!fetch_stall, "R9 stall released", fetch_stall, 0);
        chk(dones == 1, "R5 one completion", dones, 1);
        chk(issued == N, "R2 all lines issued", issued, N);
    endtask

    task automatic do_fill(input int i);
        @(negedge clk);
        fill_valid = 1; fill_idx = IDX_W'(i);
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic start_sync();
        @(negedge clk);
        sync_req = 1;
        @(negedge clk);
        sync_req = 0;
        issued = 0; owed = 0; dones = 0;
    endtask

    task automatic probe_all_invalid(input string req);
        for (int i = 0; i < N; i++) begin
            probe_idx = IDX_W'(i);
            #1;
            chk(!probe_hit, req, probe_hit, 0);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk(!evict_valid, "R1 no eviction", evict_valid, 0);
        chk(!fetch_stall, "R1 no stall", fetch_stall, 0);
        chk(!proto_err, "R1 no error", proto_err, 0);
        chk(!sync_done, "R1 no done", sync_done, 0);
        probe_all_invalid("R1 lines invalid");

        // Table-driven sweeps
        foreach (VEC[v]) begin
            logic [7:0] fm, rm, dm;
            int cyc;
            {fm, rm, dm} = VEC[v];
            for (int i = 0; i < N; i++) if (fm[i]) begin
                do_fill(i);
                probe_idx = IDX_W'(i);
                #1;
                chk(probe_hit, "R10 fill sets line", probe_hit, 1);
            end
            start_sync();
            cyc = 0;
            while (dones == 0 && cyc < 300) begin
                @(negedge clk);
                step(rm[cyc % 8], dm[cyc % 8]);
                cyc++;
            end
            @(negedge clk);
            evict_ready = 0; evict_done = 0;
            #1;
            chk(!sync_done, "R5 single-cycle done", sync_done, 0);
            chk(dones == 1, "R5 one completion", dones, 1);
            chk(issued == N, "R2 all lines issued", issued, N);
            chk(!proto_err, "R7 no error on clean sweep", proto_err, 0);
            probe_all_invalid("R4 lines invalid after sweep");
        end

        // R3 back-pressure hold, R9 fill dropped, R8 overlap
        do_fill(0);
        start_sync();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            step(1'b0, 1'b0);
            chk(evict_valid && evict_idx == 0, "R3 hold under back-pressure", evict_idx, 0);
        end
        @(negedge clk);
        step(1'b1, 1'b0);
        @(negedge clk);
        fill_valid = 1; fill_idx = '0;
        sync_req = 1;
        step(1'b0, 1'b0);
        @(negedge clk);
        fill_valid = 0; sync_req = 0;
        step(1'b0, 1'b0);
        chk(proto_err, "R8 overlap flagged", proto_err, 1);
        chk(evict_idx == 1, "R8 sweep not restarted", evict_idx, 1);
        finish_sweep();
        probe_idx = '0;
        #1;
        chk(!probe_hit, "R9 fill during sweep dropped", probe_hit, 0);
        chk(proto_err, "R7 error sticky", proto_err, 1);

        // Reset clears error
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        #1;
        chk(!proto_err, "R1 error cleared by reset", proto_err, 0);

        // R7 spurious callback while idle
        @(negedge clk);
        evict_done = 1;
        @(negedge clk);
        evict_done = 0;
        #1;
        chk(proto_err, "R7 spurious callback flagged", proto_err, 1);
        chk(!fetch_stall && !sync_done, "R7 callback has no other effect", fetch_stall, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule